// File: doc/BRIEF.md
# Parallel Trace Port Serializer

This block takes a stream of trace bytes, grouped into variable-length messages, and drives a trace clock pin plus up to sixteen trace data pins. A mode code picks how many data lines carry the stream: 1, 2, 4, 8 or 16. Bytes go out least significant bit first, and each beat carries as many bits as there are lines. A divider sets the timebase. In the normal timing, data changes on every trace clock edge. An optional clock-centred timing halves the data rate and places each trace clock edge in the middle of a data beat. The receiver samples on both clock edges in either timing.

Upstream logic offers bytes over a valid/ready handshake, with a flag on the last byte of each message. Inside the block there is a small byte FIFO and a shift register that splits each byte into beats. When nothing is buffered, the data lines sit at idle. When the next message's bytes are already waiting, it starts on the clock edge right after the previous one ends. An empty flag tells the controlling logic when the internal buffers have drained, so the mode can be changed safely.

Top module: `trace_par_tx`

## Requirements
- R1: Mode codes 8, 9, 10, 11 and 12 select 1, 2, 4, 8 and 16 data lines. With any other code the trace clock is held low, the data lines are 0 and `ready_o` is 0.
- R2: Without centring, the trace clock toggles once every `div_i`+1 input clock cycles, and a new data beat appears with every toggle.
- R3: With `center_i` set, the trace clock toggles once every 2·(`div_i`+1) cycles and a beat lasts 2·(`div_i`+1) cycles. Each clock edge falls halfway between two data changes.
- R4: Bytes are sent least significant bit first. Line 0 carries the lowest bit of each beat, and lines above the selected width stay 0.
- R5: In 16-bit mode (code 12), lines 7..0 carry the earlier byte and lines 15..8 carry the byte after it, in the same beat.
- R6: In 16-bit mode, a message that ends on an odd byte drives 0 on lines 15..8 in its final beat. The next message starts in a fresh beat.
- R7: When the bytes of the next message are already buffered, its first beat follows the previous message's last beat with no idle beat in between.
- R8: While `enable_i` is 0, `ready_o` is 0, the data lines are 0, and the trace clock keeps toggling in a valid mode.
- R9: `empty_o` is 1 exactly when no byte is held in the FIFO or in the beat shift register.
- R10: When no byte is available at a beat, all data lines are 0.
- R11: After reset, the trace clock and data lines are 0 and `empty_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Line-count mode code |
| div_i | input | DIV_W | Timebase divider; the period is value+1 cycles |
| center_i | input | 1 | Clock-centred timing select |
| enable_i | input | 1 | Output enable |
| byte_i | input | 8 | Trace byte |
| valid_i | input | 1 | Byte offered |
| last_i | input | 1 | Byte ends a message |
| ready_o | output | 1 | Byte accepted on this cycle if valid |
| trc_clk_o | output | 1 | Trace clock |
| trc_data_o | output | 16 | Trace data lines |
| empty_o | output | 1 | No byte buffered internally |

## Verification
The bench streams several messages of one to five bytes in each line width and in both timings. It checks every beat against a queue built from the byte order rule.

- Odd-length messages in 16-bit mode are the main trap. A design that keeps pairing bytes across a message boundary would shift every later beat by one byte lane.
- Centred timing is checked by the spacing of clock edges. A design that toggles the clock on beat changes would show the wrong half period and would sample data at its edges.
- A divider of zero is exercised, which catches an off-by-one in the timebase.
- The bench offers bytes while the output is disabled and checks that none are taken.

// File: rtl/trace_par_pkg.sv
package trace_par_pkg;
  localparam int BYTE_W = 8;
  localparam int LINES  = 16;

  typedef enum logic [2:0] {W1, W2, W4, W8, W16, WOFF} width_e;

  typedef struct packed {
    logic              last;
    logic [BYTE_W-1:0] data;
  } ent_t;

  function automatic width_e decode_mode(input logic [3:0] m);
    case (m)
      4'd8:    return W1;
      4'd9:    return W2;
      4'd10:   return W4;
      4'd11:   return W8;
      4'd12:   return W16;
      default: return WOFF;
    endcase
  endfunction

  function automatic logic [4:0] lane_bits(input width_e w);
    case (w)
      W1:      return 5'd1;
      W2:      return 5'd2;
      W4:      return 5'd4;
      default: return 5'd8;
    endcase
  endfunction
endpackage

// File: rtl/trace_par_timebase.sv
module trace_par_timebase #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             beat_o,
  output logic             trc_clk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q, clk_q;
  logic             tick;

  assign tick      = run_i && (cnt_q >= div_i);
  // centred: beats on even ticks, clock edges on odd ticks
  assign beat_o    = tick && (!center_i || !phase_q);
  assign trc_clk_o = clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      clk_q   <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) begin
        phase_q <= ~phase_q;
        if (!center_i || phase_q) clk_q <= ~clk_q;
      end
    end
  end

  p_off_clk_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !trc_clk_o);
  p_center_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_o && center_i) |=> $stable(trc_clk_o));
endmodule

// File: rtl/trace_par_fifo.sv
module trace_par_fifo
  import trace_par_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  ent_t              din_i,
  input  logic [1:0]        pop_i,
  output logic [CNT_W-1:0]  cnt_o,
  output ent_t              head0_o,
  output logic [BYTE_W-1:0] head1_data_o
);
  localparam int PTR_W = $clog2(DEPTH);

  ent_t             mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, rd_nx;
  logic [CNT_W-1:0] cnt_q;

  assign rd_nx        = rd_q + 1'b1;
  assign head0_o      = mem[rd_q];
  assign head1_data_o = mem[rd_nx].data;
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      rd_q  <= rd_q + PTR_W'(pop_i);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CNT_W'(DEPTH));
  p_no_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(pop_i) <= cnt_q);
endmodule

// File: rtl/trace_par_packer.sv
module trace_par_packer
  import trace_par_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  width_e            width_i,
  input  logic              en_i,
  input  logic              beat_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  ent_t              head0_i,
  input  logic [BYTE_W-1:0] head1_data_i,
  output logic [1:0]        pop_o,
  output logic              busy_o,
  output logic [LINES-1:0]  data_o
);
  logic [BYTE_W-1:0] sh_q, sh_nx;
  logic [3:0]        left_q, left_nx;
  logic [LINES-1:0]  data_q, data_nx, mask;
  logic [4:0]        nbits;
  logic [1:0]        pop;

  assign nbits = lane_bits(width_i);
  assign mask  = LINES'((17'd1 << nbits) - 17'd1);

  always_comb begin
    pop     = 2'd0;
    data_nx = '0;
    sh_nx   = sh_q;
    left_nx = left_q;
    if (width_i == W16) begin
      if (cnt_i >= CNT_W'(2) && !head0_i.last) begin
        pop     = 2'd2;
        data_nx = {head1_data_i, head0_i.data};
      end else if (cnt_i != '0 && head0_i.last) begin
        pop     = 2'd1;  // odd tail: upper lane idles
        data_nx = {8'h00, head0_i.data};
      end
    end else if (width_i != WOFF) begin
      if (left_q != '0) begin
        data_nx = LINES'(sh_q) & mask;
        sh_nx   = sh_q >> nbits;
        left_nx = left_q - nbits[3:0];
      end else if (cnt_i != '0) begin
        pop     = 2'd1;
        data_nx = LINES'(head0_i.data) & mask;
        sh_nx   = head0_i.data >> nbits;
        left_nx = 4'd8 - nbits[3:0];
      end
    end
  end

  assign pop_o  = (en_i && beat_i) ? pop : 2'd0;
  assign busy_o = (left_q != '0);
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
    end else if (!en_i || width_i == WOFF) begin
      data_q <= '0;
    end else if (beat_i) begin
      data_q <= data_nx;
      sh_q   <= sh_nx;
      left_q <= left_nx;
    end
  end

  p_idle_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> data_o == '0);
  p_pad_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_i == W16 && en_i && pop_o == 2'd1) |=> data_o[15:8] == 8'h00);
endmodule

// File: rtl/trace_par_tx.sv
module trace_par_tx
  import trace_par_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             center_i,
  input  logic             enable_i,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             ready_o,
  output logic             trc_clk_o,
  output logic [15:0]      trc_data_o,
  output logic             empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  width_e            width;
  logic              run, beat, push, busy;
  logic [1:0]        pop;
  logic [CNT_W-1:0]  cnt;
  ent_t              head0, din;
  logic [BYTE_W-1:0] head1_data;

  assign width   = decode_mode(mode_i);
  assign run     = (width != WOFF);
  assign ready_o = run && enable_i && (cnt < CNT_W'(DEPTH));
  assign push    = valid_i && ready_o;
  assign din     = '{last: last_i, data: byte_i};
  assign empty_o = (cnt == '0) && !busy;

  trace_par_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk_i, .rst_ni, .run_i(run), .center_i, .div_i,
    .beat_o(beat), .trc_clk_o
  );

  trace_par_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(din), .pop_i(pop),
    .cnt_o(cnt), .head0_o(head0), .head1_data_o(head1_data)
  );

  trace_par_packer #(.CNT_W(CNT_W)) u_pack (
    .clk_i, .rst_ni, .width_i(width), .en_i(enable_i), .beat_i(beat),
    .cnt_i(cnt), .head0_i(head0), .head1_data_i(head1_data),
    .pop_o(pop), .busy_o(busy), .data_o(trc_data_o)
  );

  p_ready_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> enable_i);
  p_off_no_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !ready_o);
endmodule

// File: tb/sim_trace_par_tx.sv
module sim_trace_par_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] div = 16'd0;
  logic        center = 1'b0, enable = 1'b0;
  logic [7:0]  byte_in = 8'd0;
  logic        valid = 1'b0, last = 1'b0;
  logic        ready, trc_clk, empty;
  logic [15:0] trc_data;

  trace_par_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .div_i(div),
    .center_i(center), .enable_i(enable), .byte_i(byte_in),
    .valid_i(valid), .last_i(last), .ready_o(ready),
    .trc_clk_o(trc_clk), .trc_data_o(trc_data), .empty_o(empty)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0]  in_q[$];
  bit          last_q[$];
  logic [15:0] exp_q[$];
  bit          feed_en = 0, take = 0, started = 0;
  int          half_exp = 0, tog_cnt = 0, last_tog = 0;
  string       req_t = "R2", req_d = "R4";
  logic        prev_clk = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // driver: offers queued bytes, pops on handshake
  initial forever begin
    @(negedge clk);
    if (take) begin
      void'(in_q.pop_front());
      void'(last_q.pop_front());
    end
    if (feed_en && in_q.size() > 0) begin
      valid = 1'b1; byte_in = in_q[0]; last = last_q[0];
    end else valid = 1'b0;
    #1 take = valid && ready;
  end

  // monitor: one beat per trace clock edge
  always @(negedge clk) begin
    if (rst_n && trc_clk !== prev_clk) begin
      if (tog_cnt >= 2 && half_exp > 0) chk(cyc - last_tog == half_exp, req_t, cyc - last_tog, half_exp);
      last_tog = cyc;
      tog_cnt++;
      if (exp_q.size() > 0) begin
        if (started || trc_data != 16'h0) begin
          started = 1;
          chk(trc_data == exp_q[0], req_d, trc_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end else if (started) chk(trc_data == 16'h0, "R10", trc_data, 0);
    end
    prev_clk = trc_clk;
  end

  task automatic run_case(input logic [3:0] m, input bit c, input int d, input int nmsg,
                          input int base, input string rd);
    logic [7:0] b[$];
    bit         l[$];
    int         w;
    for (int k = 0; k < nmsg; k++) begin
      int len = 1 + ((k * 3 + base) % 5);
      for (int j = 0; j < len; j++) begin
        logic [7:0] v = 8'((k * 37 + j * 11 + base * 5) & 255);
        if (b.size() == 0) v[0] = 1'b1;
        b.push_back(v);
        l.push_back(j == len - 1);
      end
    end
    w = (m == 4'd8) ? 1 : (m == 4'd9) ? 2 : (m == 4'd10) ? 4 : (m == 4'd11) ? 8 : 16;
    if (w == 16) begin
      for (int i = 0; i < b.size(); ) begin
        if (l[i]) begin exp_q.push_back({8'h00, b[i]}); i++; end
        else begin exp_q.push_back({b[i+1], b[i]}); i += 2; end
      end
    end else begin
      for (int i = 0; i < b.size(); i++)
        for (int s = 0; s < 8; s += w)
          exp_q.push_back(16'((b[i] >> s) & ((1 << w) - 1)));
    end
    @(posedge clk); #2;
    mode = m; center = c; div = 16'(d);
    half_exp = c ? 2 * (d + 1) : d + 1;
    req_t = c ? "R3" : "R2";
    req_d = rd;
    tog_cnt = 0; started = 0;
    repeat (12 * (d + 1)) @(posedge clk);
    #2;
    foreach (b[i]) begin in_q.push_back(b[i]); last_q.push_back(l[i]); end
    feed_en = 1; enable = 1'b1;
    for (int t = 0; t < 8000 && exp_q.size() > 0; t++) @(posedge clk);
    chk(exp_q.size() == 0, rd, exp_q.size(), 0);
    repeat (16 * (d + 1)) @(posedge clk);
    #2;
    chk(empty == 1'b1, "R9", empty, 1);
    enable = 1'b0; feed_en = 0; started = 0;
    exp_q.delete();
  endtask

  initial begin
    #10000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(trc_clk == 1'b0, "R11", trc_clk, 0);
    chk(trc_data == 16'h0, "R11", trc_data, 0);
    chk(empty == 1'b1, "R11", empty, 1);

    // R1: invalid mode code keeps clock low and refuses bytes
    @(posedge clk); #2;
    mode = 4'd5; enable = 1'b1; valid = 1'b0;
    tog_cnt = 0; half_exp = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(tog_cnt == 0, "R1", tog_cnt, 0);
    chk(ready == 1'b0, "R1", ready, 0);
    chk(trc_data == 16'h0, "R1", trc_data, 0);
    @(posedge clk); #2 enable = 1'b0;

    run_case(4'd8, 1'b0, 1, 3, 0, "R4");   // 1 line
    run_case(4'd9, 1'b0, 0, 4, 1, "R4");   // 2 lines, divider 0
    run_case(4'd10, 1'b1, 1, 4, 2, "R3");  // 4 lines centred
    run_case(4'd11, 1'b0, 2, 6, 3, "R7");  // 8 lines, back-to-back messages
    run_case(4'd12, 1'b0, 3, 6, 4, "R5");  // 16 lines, odd tails per R6
    run_case(4'd12, 1'b1, 1, 5, 2, "R6");
    run_case(4'd8, 1'b1, 0, 2, 5, "R4");

    // R8: disabled output takes nothing, lines idle, clock runs
    @(posedge clk); #2;
    mode = 4'd11; center = 1'b0; div = 16'd1; half_exp = 0; tog_cnt = 0;
    in_q.push_back(8'hA5); last_q.push_back(1'b1);
    in_q.push_back(8'h3C); last_q.push_back(1'b1);
    feed_en = 1;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      #2;
      if (ready !== 1'b0 || trc_data !== 16'h0) begin
        chk(1'b0, "R8", {ready, trc_data}, 0);
        break;
      end
    end
    checks++;
    chk(in_q.size() == 2, "R8", in_q.size(), 2);
    chk(tog_cnt > 5, "R8", tog_cnt, 6);
    chk(empty == 1'b1, "R9", empty, 1);
    feed_en = 0; in_q.delete(); last_q.delete();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule